// File: doc/BRIEF.md
# Streamed-Direction Iterative CORDIC Rotator

This block carries out the vector-rotation part of a circular CORDIC sine and cosine computation, one micro-rotation per accepted input word. A host keeps the residual angle and its arctangent table. For each step it decides whether the vector turns clockwise or counter-clockwise, and it sends that single decision bit over a valid/ready input stream. The block holds the x and y coordinates in wide registers with guard bits. It turns them with shift-and-add operations and counts the steps.

Once the last micro-rotation has been applied, the block returns the two coordinates on a valid/ready output stream, cosine first and sine second. It then waits for the direction word that starts the next computation. That first word reloads the coordinates with the gain-compensation constant and zero and applies step zero in the same cycle, so a computation costs exactly as many input beats as there are micro-rotations. Direction words are not accepted while results are waiting, so the host can queue the next computation's first word early.

Top module: `cordic_rot`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: The first direction word after reset, or after the sine beat has been taken, starts from x = round(0.60725·2^20) = 636748 and y = 0 in the 22-bit internal format (20 fractional bits), and applies micro-rotation 0 to those values.
- R3: Accepted direction word number i (0-based) updates both coordinates at once from their old values: x' = x − σ·(y >>> i), y' = y + σ·(x >>> i). The shifts are arithmetic, and the width is 22 bits.
- R4: `in_dir` = 0 selects σ = +1 (counter-clockwise) and `in_dir` = 1 selects σ = −1.
- R5: After exactly 16 accepted direction words, `out_valid` rises. While `out_valid` is high, `in_ready` is low.
- R6: The first result beat carries cosine (x) with `out_last` = 0. The second carries sine (y) with `out_last` = 1.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` stay unchanged.
- R8: A word is consumed only on a cycle where `in_valid` and `in_ready` are both 1. Idle cycles between words do not change the result.
- R9: Each result is the internal 22-bit value arithmetically shifted right by 6 and truncated to 16 bits, a signed format with 14 fractional bits.
- R10: Once the sine beat is taken, `in_ready` returns to 1 on the next cycle and a new computation can begin.
- R11: A direction word held valid while results are pending is not consumed until both result beats have been taken. It then starts the next computation.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Direction word present |
| in_ready | output | 1 | Block can take a direction word |
| in_dir | input | 1 | Rotation direction: 0 = σ +1, 1 = σ −1 |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Host takes the result beat |
| out_data | output | 16 | Cosine on the first beat, sine on the second |
| out_last | output | 1 | Marks the sine beat |

## Verification
The rotation path is driven with fixed direction patterns: all counter-clockwise, all clockwise, alternating, a single flipped first step, and a mixed word. Each pattern is compared bit-exactly against a 22-bit model, which separates errors in sign selection, shift amount and the simultaneous-update rule. Separately, directions derived from real angles are compared against true cosine and sine within a few LSBs, which exposes a wrong gain constant or output scaling. Both kinds of test run with idle gaps on the input, random backpressure on the output and back-to-back computations, so that consumption during the result phase, beat order and data holding are each observed.

// File: rtl/cordic_rot_pkg.sv
package cordic_rot_pkg;

   typedef enum logic [1:0] {
      PH_ROTATE = 2'd0,
      PH_COS    = 2'd1,
      PH_SIN    = 2'd2
   } phase_t;

endpackage

// File: rtl/cordic_rot_step.sv
module cordic_rot_step #(
   parameter int ACC_W = 22,
   parameter int SH_W  = 4
) (
   input  logic signed [ACC_W-1:0] x_i,
   input  logic signed [ACC_W-1:0] y_i,
   input  logic        [SH_W-1:0]  sh_i,
   input  logic                    neg_i,
   output logic signed [ACC_W-1:0] x_o,
   output logic signed [ACC_W-1:0] y_o
);

   logic signed [ACC_W-1:0] x_sh;
   logic signed [ACC_W-1:0] y_sh;

   assign x_sh = x_i >>> sh_i;
   assign y_sh = y_i >>> sh_i;

   always_comb begin
      if (neg_i) begin
         x_o = x_i + y_sh;
         y_o = y_i - x_sh;
      end else begin
         x_o = x_i - y_sh;
         y_o = y_i + x_sh;
      end
   end

endmodule

// File: rtl/cordic_rot_seq.sv
module cordic_rot_seq
   import cordic_rot_pkg::*;
#(
   parameter int ITERS = 16,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_fire,
   input  logic             out_fire,
   output phase_t           phase,
   output logic [CNT_W-1:0] step
);

   localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(ITERS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_ROTATE;
         step  <= '0;
      end else begin
         unique case (phase)
            PH_ROTATE: if (in_fire) begin
               if (step == LAST_STEP) begin
                  step  <= '0;
                  phase <= PH_COS;
               end else begin
                  step <= step + 1'b1;
               end
            end
            PH_COS:  if (out_fire) phase <= PH_SIN;
            PH_SIN:  if (out_fire) phase <= PH_ROTATE;
            default: phase <= PH_ROTATE;
         endcase
      end
   end

endmodule

// File: rtl/cordic_rot_fmt.sv
module cordic_rot_fmt #(
   parameter int ACC_W = 22,
   parameter int OUT_W = 16,
   parameter bit ROUND = 1'b0
) (
   input  logic signed [ACC_W-1:0] acc_i,
   output logic signed [OUT_W-1:0] res_o
);

   localparam int DROP = ACC_W - OUT_W;

   generate
      if (ROUND) begin : g_round
         logic signed [ACC_W:0] biased;
         assign biased = {acc_i[ACC_W-1], acc_i} + (ACC_W+1)'(1 << (DROP - 1));
         assign res_o  = biased[ACC_W-1:DROP];
      end else begin : g_trunc
         assign res_o = acc_i[ACC_W-1:DROP];
      end
   endgenerate

endmodule

// File: rtl/cordic_rot.sv
module cordic_rot
   import cordic_rot_pkg::*;
#(
   parameter int  OUT_W  = 16,
   parameter int  ACC_W  = 22,
   parameter int  ITERS  = 16,
   parameter real K_GAIN = 0.60725,
   parameter bit  ROUND  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic             in_dir,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [OUT_W-1:0] out_data,
   output logic             out_last
);

   localparam int CNT_W  = (ITERS > 1) ? $clog2(ITERS) : 1;
   localparam int FRAC_W = ACC_W - 2;
   localparam logic signed [ACC_W-1:0] K_FIX =
      ACC_W'(longint'(K_GAIN * (2.0 ** FRAC_W)));

   generate
      if (ACC_W <= OUT_W) begin : g_bad_width
         $error("cordic_rot: ACC_W must exceed OUT_W");
      end
      if (ITERS < 2 || ITERS >= ACC_W) begin : g_bad_iters
         $error("cordic_rot: ITERS must be in 2..ACC_W-1");
      end
   endgenerate

   phase_t                  phase;
   logic [CNT_W-1:0]        step;
   logic                    in_fire;
   logic                    out_fire;
   logic signed [ACC_W-1:0] x_q, y_q;
   logic signed [ACC_W-1:0] x_src, y_src;
   logic signed [ACC_W-1:0] x_nxt, y_nxt;
   logic signed [ACC_W-1:0] sel_acc;
   logic signed [OUT_W-1:0] sel_res;

   assign in_ready  = (phase == PH_ROTATE);
   assign out_valid = (phase == PH_COS) || (phase == PH_SIN);
   assign out_last  = (phase == PH_SIN);
   assign in_fire   = in_valid && in_ready;
   assign out_fire  = out_valid && out_ready;

   cordic_rot_seq #(.ITERS(ITERS), .CNT_W(CNT_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_fire  (in_fire),
      .out_fire (out_fire),
      .phase    (phase),
      .step     (step)
   );

   // Step zero starts from the constant pair, merging reload with rotation 0.
   assign x_src = (step == '0) ? K_FIX : x_q;
   assign y_src = (step == '0) ? '0    : y_q;

   cordic_rot_step #(.ACC_W(ACC_W), .SH_W(CNT_W)) u_step (
      .x_i   (x_src),
      .y_i   (y_src),
      .sh_i  (step),
      .neg_i (in_dir),
      .x_o   (x_nxt),
      .y_o   (y_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_q <= '0;
         y_q <= '0;
      end else if (in_fire) begin
         x_q <= x_nxt;
         y_q <= y_nxt;
      end
   end

   assign sel_acc = out_last ? y_q : x_q;

   cordic_rot_fmt #(.ACC_W(ACC_W), .OUT_W(OUT_W), .ROUND(ROUND)) u_fmt (
      .acc_i (sel_acc),
      .res_o (sel_res)
   );

   assign out_data = sel_res;

endmodule

// File: rtl/cordic_rot_chk.sv
module cordic_rot_chk #(
   parameter int OUT_W = 16,
   parameter int ITERS = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [OUT_W-1:0] out_data,
   input logic             out_last
);

   localparam int N_W = $clog2(ITERS + 1);

   logic [N_W-1:0] n_acc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         n_acc <= '0;
      end else if (out_valid && out_ready && out_last) begin
         n_acc <= '0;
      end else if (in_valid && in_ready) begin
         n_acc <= n_acc + 1'b1;
      end
   end

   // R5
   accept_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (n_acc == N_W'(ITERS)));

   // R5
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ready && out_valid));

   // R7
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

   // R6
   beat_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !out_last) |=> (out_valid && out_last));

   // R10
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

endmodule

bind cordic_rot cordic_rot_chk #(.OUT_W(OUT_W), .ITERS(ITERS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_last  (out_last)
);

// File: tb/test_cordic_rot.sv
module test_cordic_rot;

   localparam logic signed [21:0] K_REF = 22'sd636748;  // R2

   typedef struct {
      logic signed [15:0] val;
      bit                 last;
      int                 tol;
      string              req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic        in_dir = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [15:0] out_data;
   logic        out_last;

   int   checks = 0;
   int   errors = 0;
   exp_t sb[$];
   bit   rand_ready = 1'b0;
   bit   finished = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   always #10 clk = ~clk;  // 50 MHz

   cordic_rot i_cordic_rot (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_dir    (in_dir),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .out_last  (out_last)
   );

   // Bit-exact reference (R2, R3, R4, R9)
   task automatic model(input logic [15:0] dirs,
                        output logic signed [15:0] c, output logic signed [15:0] s);
      logic signed [21:0] x, y, xn, yn;
      x = K_REF;
      y = '0;
      for (int i = 0; i < 16; i++) begin
         if (dirs[i]) begin
            xn = x + (y >>> i);
            yn = y - (x >>> i);
         end else begin
            xn = x - (y >>> i);
            yn = y + (x >>> i);
         end
         x = xn;
         y = yn;
      end
      c = x[21:6];
      s = y[21:6];
   endtask

   task automatic send_word(input bit d, input int gap);
      repeat (gap) @(negedge clk);
      in_valid = 1'b1;
      in_dir   = d;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      in_dir   = ~d;
   endtask

   task automatic run_exact(input logic [15:0] dirs, input int gap, input string req);
      logic signed [15:0] c, s;
      exp_t e;
      model(dirs, c, s);
      e.val = c; e.last = 1'b0; e.tol = 0; e.req = req; sb.push_back(e);
      e.val = s; e.last = 1'b1; e.tol = 0; e.req = req; sb.push_back(e);
      for (int i = 0; i < 16; i++) send_word(dirs[i], gap);
   endtask

   // Directions derived from a real angle; result compared with true trig (R2, R9)
   task automatic run_angle(input real theta);
      real  z;
      logic [15:0] dirs;
      exp_t e;
      z = theta;
      for (int i = 0; i < 16; i++) begin
         dirs[i] = (z < 0.0);
         if (dirs[i]) z = z + $atan(2.0 ** (-i));
         else         z = z - $atan(2.0 ** (-i));
      end
      e.val = 16'($rtoi($floor($cos(theta) * 16384.0 + 0.5)));
      e.last = 1'b0; e.tol = 8; e.req = "R2 cos"; sb.push_back(e);
      e.val = 16'($rtoi($floor($sin(theta) * 16384.0 + 0.5)));
      e.last = 1'b1; e.tol = 8; e.req = "R9 sin"; sb.push_back(e);
      for (int i = 0; i < 16; i++) send_word(dirs[i], 0);
   endtask

   // Monitor: drives out_ready, then pops and compares on each handshake
   bit          prev_hold = 1'b0;
   logic [15:0] prev_data = '0;
   bit          prev_last = 1'b0;
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (prev_hold) begin
            checks++;
            if (!(out_valid && out_data == prev_data && out_last == prev_last)) begin
               errors++;
               $display("FAIL R7 hold: got v=%0b d=%0h l=%0b exp v=1 d=%0h l=%0b",
                        out_valid, out_data, out_last, prev_data, prev_last);
            end
         end
         if (out_valid && in_ready) begin
            checks++; errors++;
            $display("FAIL R5 in_ready=%0b with out_valid=%0b exp in_ready=0", in_ready, out_valid);
         end
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         out_ready = rand_ready ? lfsr[0] : 1'b1;
         if (out_valid && out_ready) begin
            exp_t e;
            int   diff;
            if (sb.size() == 0) begin
               checks++; errors++;
               $display("FAIL R5 unexpected beat got %0h exp none", out_data);
            end else begin
               e = sb.pop_front();
               diff = int'($signed(out_data)) - int'(e.val);
               if (diff < 0) diff = -diff;
               checks++;
               if (diff > e.tol || out_last != e.last) begin
                  errors++;
                  $display("FAIL %s (R6 order) got data=%0d last=%0b exp data=%0d last=%0b",
                           e.req, $signed(out_data), out_last, e.val, e.last);
               end
            end
         end
         prev_hold = out_valid && !out_ready;
         prev_data = out_data;
         prev_last = out_last;
      end
   end

   initial begin
      int wd = 0;
      while (wd < 150000 && !finished) begin
         @(posedge clk);
         wd++;
      end
      if (!finished) begin
         finished = 1'b1;
         errors++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      checks++;
      if (!(in_ready === 1'b1 && out_valid === 1'b0)) begin
         errors++;
         $display("FAIL R1 got in_ready=%0b out_valid=%0b exp 1 0", in_ready, out_valid);
      end
      // R3 R4: fixed direction patterns, exact
      run_exact(16'h0000, 0, "R3 all ccw");
      run_exact(16'hFFFF, 0, "R4 all cw");
      run_exact(16'h0001, 0, "R4 first cw");
      run_exact(16'hAAAA, 0, "R3 alternating");
      // R8: idle gaps between words
      run_exact(16'h5A3C, 3, "R8 gaps");
      // R7 R11 R10: backpressure, next word waiting during results
      rand_ready = 1'b1;
      run_exact(16'hC3E1, 0, "R11 backpressure");
      run_exact(16'h1234, 1, "R10 restart");
      // R2 R9: real angles
      run_angle(0.5);
      run_angle(-1.0);
      rand_ready = 1'b0;
      run_angle(1.2);
      run_angle(0.0);
      while (sb.size() != 0 || out_valid) @(negedge clk);
      repeat (3) @(negedge clk);
      // R10: idle and ready again after the last sine beat
      checks++;
      if (!(in_ready && !out_valid)) begin
         errors++;
         $display("FAIL R10 got in_ready=%0b out_valid=%0b exp 1 0", in_ready, out_valid);
      end
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule